// File: doc/BRIEF.md
# USB Suspend and Resume Controller

This block manages the low-power cycle of a USB device. While the device runs, it measures how long the bus has been idle. Once the bus has been idle long enough, it raises an interrupt so that firmware can choose to suspend. Firmware writes the suspend bit, and the block then turns off the oscillator enable. Every clock derived from that oscillator stops.

While suspended, the block has no clock. It watches two wake sources without one: activity on the USB bus, and a change on the key inputs compared with their value at suspend entry. Each source has its own enable. A wake turns the oscillator back on at once. The block then holds the internal clock gate closed for a programmable settling time of 1 to 20 ms, counted on the restarted oscillator. After that time it reopens the gate and clears the suspend bit. Firmware takes no part in the wake.

Top module: `usb_lp_ctrl`

## Requirements
- R1: After reset, the state is running (`state_o` = 0), `osc_en_o` = 1, `clk_gate_en_o` = 1, `idle_irq_o` = 0 and `susp_bit_o` = 0. The state codes are 0 running, 1 suspended and 2 resuming, and code 3 never appears.
- R2: While running, `idle_irq_o` rises after exactly 6*CYC_PER_MS consecutive clock edges with `bus_act_i` low, and stays high while the bus stays idle. One edge with `bus_act_i` high clears it after that edge and restarts the count from zero.
- R3: A `susp_req_i` pulse while running moves the block to suspended on the next edge. In that state `osc_en_o` = 0, `clk_gate_en_o` = 0 and `susp_bit_o` = 1.
- R4: While suspended with no enabled wake event, `osc_en_o` stays 0 and the state stays suspended.
- R5: While suspended, bus activity raises `osc_en_o` with no clock edge needed, but only when `wake_bus_en_i` = 1. With the enable at 0, bus activity is ignored.
- R6: While suspended, any `key_i` bit that differs from its value at the suspend-entry edge raises `osc_en_o` with no clock, but only when `wake_key_en_i` = 1. With the enable at 0, a key change is ignored.
- R7: A wake always moves the state from suspended to resuming on the first restarted edge. While resuming, `osc_en_o` = 1, `clk_gate_en_o` = 0, and `susp_req_i` is ignored.
- R8: Resuming lasts exactly ms*CYC_PER_MS edges after the entry edge, where ms = 1 + (19*`resume_sel_i` + 7) div 15. So code 0 gives 1 ms, 3 gives 5, 7 gives 10 and 15 gives 20.
- R9: When resuming ends, the state is running, `clk_gate_en_o` = 1 and `susp_bit_o` = 0. No further suspend happens without a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-derived clock; stops while the oscillator is off |
| rst_ni | input | 1 | Asynchronous reset, active low |
| susp_req_i | input | 1 | One-cycle write of the suspend bit |
| wake_bus_en_i | input | 1 | Enables wake on bus activity |
| wake_key_en_i | input | 1 | Enables wake on key change |
| resume_sel_i | input | 4 | Resume duration code |
| bus_act_i | input | 1 | USB bus non-idle indication |
| key_i | input | KEY_W | Key status inputs |
| idle_irq_o | output | 1 | Bus-idle interrupt to the CPU |
| osc_en_o | output | 1 | Oscillator enable |
| clk_gate_en_o | output | 1 | Internal clock gate enable |
| susp_bit_o | output | 1 | Suspend bit readback |
| state_o | output | 2 | Current state code |

## Verification
A wrong state shows at the ports almost at once. A lost wake latch leaves `osc_en_o` low after an enabled event and hangs the clock. A false wake raises `osc_en_o` during an ignored event, in the same delta. A resume counter that loads the wrong value moves the reopening of `clk_gate_en_o` by whole milliseconds, and that shift is measured to the edge. An idle counter that does not restart shows as an early `idle_irq_o` one count window after the activity.

// File: rtl/usb_lp_pkg.sv
package usb_lp_pkg;
   typedef enum logic [1:0] {
      LP_RUN   = 2'd0,
      LP_SLEEP = 2'd1,
      LP_WAKE  = 2'd2
   } lp_state_e;

   localparam int unsigned IDLE_MS    = 6;
   localparam int unsigned RES_MAX_MS = 20;

   // maps a 4-bit code evenly onto 1..20 ms
   function automatic int unsigned resume_ms(input logic [3:0] code);
      return 1 + (int'(code) * 19 + 7) / 15;
   endfunction
endpackage

// File: rtl/usb_lp_idle_timer.sv
module usb_lp_idle_timer #(
   parameter int unsigned IDLE_CYC = 6000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic act_i,
   output logic irq_o
);
   localparam int unsigned CW = $clog2(IDLE_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q <= '0;
      else if (!run_i || act_i)        cnt_q <= '0;
      else if (cnt_q != CW'(IDLE_CYC)) cnt_q <= cnt_q + 1'b1;
   end

   assign irq_o = run_i && (cnt_q == CW'(IDLE_CYC));
endmodule

// File: rtl/usb_lp_wake_detect.sv
module usb_lp_wake_detect #(
   parameter int unsigned KEY_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             armed_i,
   input  logic             bus_en_i,
   input  logic             key_en_i,
   input  logic             bus_act_i,
   input  logic [KEY_W-1:0] key_i,
   output logic             pend_o
);
   logic [KEY_W-1:0] key_snap_q;
   logic [KEY_W-1:0] key_diff;
   logic             wake_set;
   logic             pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    key_snap_q <= '0;
      else if (run_i) key_snap_q <= key_i;
   end

   for (genvar i = 0; i < KEY_W; i++) begin : g_key_cmp
      assign key_diff[i] = key_i[i] ^ key_snap_q[i];
   end

   assign wake_set = armed_i && ((bus_en_i && bus_act_i) || (key_en_i && (|key_diff)));

   // set without a clock: the oscillator is off while armed
   always_ff @(posedge clk_i or negedge rst_ni or posedge wake_set) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (wake_set) pend_q <= 1'b1;
      else if (!armed_i) pend_q <= 1'b0;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/usb_lp_resume_timer.sv
module usb_lp_resume_timer
   import usb_lp_pkg::*;
#(
   parameter int unsigned CYC_PER_MS = 1000
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       load_i,
   input  logic [3:0] code_i,
   output logic       done_o
);
   localparam int unsigned MAX_CYC = RES_MAX_MS * CYC_PER_MS;
   localparam int unsigned CW      = $clog2(MAX_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (load_i)       cnt_q <= CW'(resume_ms(code_i) * CYC_PER_MS - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/usb_lp_ctrl.sv
module usb_lp_ctrl
   import usb_lp_pkg::*;
#(
   parameter int unsigned CYC_PER_MS = 1000,
   parameter int unsigned KEY_W      = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             susp_req_i,
   input  logic             wake_bus_en_i,
   input  logic             wake_key_en_i,
   input  logic [3:0]       resume_sel_i,
   input  logic             bus_act_i,
   input  logic [KEY_W-1:0] key_i,
   output logic             idle_irq_o,
   output logic             osc_en_o,
   output logic             clk_gate_en_o,
   output logic             susp_bit_o,
   output logic [1:0]       state_o
);
   localparam int unsigned IDLE_CYC = IDLE_MS * CYC_PER_MS;

   if (CYC_PER_MS < 1) begin : g_bad_cpm
      $error("CYC_PER_MS must be at least 1");
   end
   if (KEY_W < 1) begin : g_bad_key
      $error("KEY_W must be at least 1");
   end

   lp_state_e state_q, state_d;
   logic      susp_q;
   logic      pend;
   logic      res_done;
   logic      res_load;
   logic      in_run;
   logic      in_sleep;

   assign in_run   = (state_q == LP_RUN);
   assign in_sleep = (state_q == LP_SLEEP);
   assign res_load = in_sleep && pend;

   usb_lp_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (in_run),
      .act_i (bus_act_i),
      .irq_o (idle_irq_o)
   );

   usb_lp_wake_detect #(.KEY_W(KEY_W)) u_wake (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (in_run),
      .armed_i  (in_sleep),
      .bus_en_i (wake_bus_en_i),
      .key_en_i (wake_key_en_i),
      .bus_act_i(bus_act_i),
      .key_i    (key_i),
      .pend_o   (pend)
   );

   usb_lp_resume_timer #(.CYC_PER_MS(CYC_PER_MS)) u_res (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(res_load),
      .code_i(resume_sel_i),
      .done_o(res_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LP_RUN:   if (susp_req_i) state_d = LP_SLEEP;
         LP_SLEEP: if (pend)       state_d = LP_WAKE;
         LP_WAKE:  if (res_done)   state_d = LP_RUN;
         default:                  state_d = LP_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LP_RUN;
         susp_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (in_run && susp_req_i)                          susp_q <= 1'b1;
         else if (state_q == LP_WAKE && state_d == LP_RUN)  susp_q <= 1'b0;
      end
   end

   assign osc_en_o      = !in_sleep || pend;
   assign clk_gate_en_o = in_run;
   assign susp_bit_o    = susp_q;
   assign state_o       = state_q;
endmodule

// File: rtl/usb_lp_ctrl_chk.sv
module usb_lp_ctrl_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       susp_req_i,
   input logic       bus_act_i,
   input logic       idle_irq_o,
   input logic       osc_en_o,
   input logic       clk_gate_en_o,
   input logic       susp_bit_o,
   input logic [1:0] state_o
);
   AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o != 2'd3); // R1
   AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'd0 && bus_act_i) |=> !idle_irq_o); // R2
   AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'd0 && susp_req_i) |=> (state_o == 2'd1 && !clk_gate_en_o && susp_bit_o)); // R3
   AST_WAKE_FROM_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'd2 && $past(state_o) != 2'd2) |-> $past(state_o) == 2'd1); // R7
   AST_WAKE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o == 2'd2 |-> (osc_en_o && !clk_gate_en_o)); // R7
   AST_NO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o == 2'd1 |=> state_o != 2'd0); // R7
   AST_RUN_BIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o == 2'd0 |-> !susp_bit_o); // R9
endmodule

bind usb_lp_ctrl usb_lp_ctrl_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .susp_req_i   (susp_req_i),
   .bus_act_i    (bus_act_i),
   .idle_irq_o   (idle_irq_o),
   .osc_en_o     (osc_en_o),
   .clk_gate_en_o(clk_gate_en_o),
   .susp_bit_o   (susp_bit_o),
   .state_o      (state_o)
);

// File: tb/usb_lp_ctrl_tb_top.sv
module usb_lp_ctrl_tb_top;
   localparam int CPM   = 4;
   localparam int KW    = 4;
   localparam int IDLE  = 6 * CPM;
   localparam int NVEC  = 4;
   // {wake via key, code, expected ms}
   localparam logic [12:0] VEC [NVEC] = '{
      {1'b0, 4'd0,  8'd1},
      {1'b1, 4'd15, 8'd20},
      {1'b1, 4'd7,  8'd10},
      {1'b0, 4'd3,  8'd5}
   };

   logic          clk_free = 1'b0;
   logic          clk;
   logic          rst_ni = 1'b0;
   logic          susp_req_i = 1'b0;
   logic          wake_bus_en_i = 1'b1;
   logic          wake_key_en_i = 1'b1;
   logic [3:0]    resume_sel_i = '0;
   logic          bus_act_i = 1'b0;
   logic [KW-1:0] key_i = '0;
   logic          idle_irq_o, osc_en_o, clk_gate_en_o, susp_bit_o;
   logic [1:0]    state_o;

   int n_chk = 0;
   int n_err = 0;
   int edge_cnt = 0;
   bit done = 0;

   always #5 clk_free = ~clk_free;
   assign clk = clk_free & osc_en_o;
   always @(posedge clk) edge_cnt++;

   usb_lp_ctrl #(.CYC_PER_MS(CPM), .KEY_W(KW)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .susp_req_i(susp_req_i),
      .wake_bus_en_i(wake_bus_en_i), .wake_key_en_i(wake_key_en_i),
      .resume_sel_i(resume_sel_i), .bus_act_i(bus_act_i), .key_i(key_i),
      .idle_irq_o(idle_irq_o), .osc_en_o(osc_en_o), .clk_gate_en_o(clk_gate_en_o),
      .susp_bit_o(susp_bit_o), .state_o(state_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk_free);
   endtask

   task automatic enter_sleep();
      @(negedge clk_free) susp_req_i = 1'b1;
      @(negedge clk_free) susp_req_i = 1'b0;
      chk("R3 state", state_o, 1);
      chk("R3 osc off", osc_en_o, 0);
      chk("R3 gate off", clk_gate_en_o, 0);
      chk("R3 susp bit", susp_bit_o, 1);
      tick(3);
      chk("R4 stays asleep", state_o, 1);
      chk("R4 osc stays off", osc_en_o, 0);
   endtask

   // fires a wake, then measures the clock-gated window in edges
   task automatic wake_and_measure(input bit by_key, input int exp_ms, input string tag);
      int e0;
      e0 = edge_cnt;
      @(negedge clk_free);
      if (by_key) key_i = key_i ^ KW'(1);
      else        bus_act_i = 1'b1;
      #1;
      chk(by_key ? "R6 key wake osc on" : "R5 bus wake osc on", osc_en_o, 1);
      @(negedge clk_free) bus_act_i = 1'b0;
      chk("R7 resuming state", state_o, 2);
      chk("R7 gate masked", clk_gate_en_o, 0);
      for (int i = 0; i < 3000 && !clk_gate_en_o; i++) @(negedge clk_free);
      chk({"R8 resume edges ", tag}, edge_cnt - e0, exp_ms * CPM + 1);
      chk("R9 back to run", state_o, 0);
      chk("R9 susp bit cleared", susp_bit_o, 0);
   endtask

   initial begin
      tick(3);
      chk("R1 state", state_o, 0);
      chk("R1 osc", osc_en_o, 1);
      chk("R1 gate", clk_gate_en_o, 1);
      chk("R1 irq", idle_irq_o, 0);
      chk("R1 susp", susp_bit_o, 0);
      rst_ni = 1'b1;

      // R2 idle interrupt timing
      tick(IDLE - 1);
      chk("R2 irq before limit", idle_irq_o, 0);
      tick(1);
      chk("R2 irq at limit", idle_irq_o, 1);
      tick(2);
      chk("R2 irq held", idle_irq_o, 1);
      bus_act_i = 1'b1;
      tick(1);
      bus_act_i = 1'b0;
      chk("R2 irq cleared", idle_irq_o, 0);
      tick(IDLE - 1);
      chk("R2 restart no early irq", idle_irq_o, 0);
      tick(1);
      chk("R2 restart irq", idle_irq_o, 1);

      // table of resume codes and wake sources
      for (int v = 0; v < NVEC; v++) begin
         resume_sel_i = VEC[v][11:8];
         enter_sleep();
         wake_and_measure(VEC[v][12], int'(VEC[v][7:0]), $sformatf("code%0d", VEC[v][11:8]));
         tick(2);
      end

      // R5 bus wake disabled, then key wake
      wake_bus_en_i = 1'b0;
      resume_sel_i  = 4'd1;
      enter_sleep();
      @(negedge clk_free) bus_act_i = 1'b1;
      #1 chk("R5 disabled bus ignored osc", osc_en_o, 0);
      @(negedge clk_free) bus_act_i = 1'b0;
      chk("R5 disabled bus ignored state", state_o, 1);
      wake_and_measure(1'b1, 2, "code1");
      wake_bus_en_i = 1'b1;

      // R6 key wake disabled, then bus wake
      wake_key_en_i = 1'b0;
      resume_sel_i  = 4'd0;
      enter_sleep();
      @(negedge clk_free) key_i = key_i ^ KW'(4'b0100);
      #1 chk("R6 disabled key ignored osc", osc_en_o, 0);
      tick(2);
      chk("R6 disabled key ignored state", state_o, 1);
      wake_and_measure(1'b0, 1, "code0");
      wake_key_en_i = 1'b1;

      // R7 suspend request during resume is ignored
      resume_sel_i = 4'd15;
      enter_sleep();
      @(negedge clk_free) bus_act_i = 1'b1;
      @(negedge clk_free) bus_act_i = 1'b0;
      tick(3);
      susp_req_i = 1'b1;
      tick(1);
      susp_req_i = 1'b0;
      chk("R7 request ignored in resume", state_o, 2);
      for (int i = 0; i < 3000 && !clk_gate_en_o; i++) @(negedge clk_free);
      tick(2);
      chk("R9 stays running", state_o, 0);
      chk("R9 no stale suspend bit", susp_bit_o, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_free);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule